// File: doc/BRIEF.md
# PCI Configuration Access Port

This block gives a host on an I/O bus a path into PCI configuration space. It uses two I/O locations. A 32-bit pointer register holds the bus, device/function and register selection. A four-byte data window reaches the configuration dword that the pointer selects. The low two I/O address bits of a window access pick the first byte lane, and the access size picks how many lanes are touched. Each enabled window access becomes one configuration request toward a single downstream target. The request carries a 24-bit configuration address, lane-aligned byte enables, lane-aligned write data and a read/write flag.

Both interfaces use a simple handshake. The host raises `io_req_i` with its fields held stable until `io_ready_o` pulses for one cycle. Pointer accesses and accesses that make no request complete one cycle after acceptance. A window access holds `cfg_req_o` and every request field steady until the target returns `cfg_rsp_valid_i`. For a read, the target data is then right-aligned and trimmed to the access size before it is handed back. Writes are acknowledged the same way, so a write reaches the host as complete only after the target has taken it.

Top module: `cfg_access_port`

## Requirements
- R1: During reset and after it, `io_ready_o` and `cfg_req_o` are low and the pointer register holds zero, so the first dword read of the pointer returns 0x00000000.
- R2: The pointer register sits at I/O address 0xCF8. A dword access there (size code 2) writes all 32 bits. A later dword read returns exactly the last value written, including bits 1:0 and 30:24.
- R3: The following accesses make no configuration request and do not change the pointer: a byte (size 0) or word (size 1) access at 0xCF8, any access at 0xCF9–0xCFB, and any access outside 0xCF8–0xCFF. Reads of these return 0xFFFFFFFF.
- R4: A window access (0xCFC–0xCFF) while pointer bit 31 is clear makes no configuration request. A read returns 0xFFFFFFFF.
- R5: While pointer bit 31 is set, a window access issues one request. Its `cfg_addr_o` is {pointer[23:16] bus, pointer[15:8] device/function, pointer[7:2] dword offset, 2'b00}. Pointer bits 30:24 and 1:0 do not reach the request.
- R6: `cfg_be_o` enables N consecutive lanes starting at lane io_addr[1:0], where N is 1, 2 or 4 for size codes 0, 1 and 2. Lanes past lane 3 are dropped.
- R7: On a write, `cfg_wdata_o` equals the right-aligned `io_wdata_i` shifted left by 8 × io_addr[1:0] bits.
- R8: On a read, `io_rdata_o` equals `cfg_rdata_i` shifted right by 8 × io_addr[1:0] bits, with only the low N bytes kept and the rest zero.
- R9: Once raised, `cfg_req_o` stays high with `cfg_addr_o`, `cfg_be_o`, `cfg_we_o` and `cfg_wdata_o` unchanged until the cycle in which `cfg_rsp_valid_i` is high. It drops in the next cycle.
- R10: Each I/O access produces exactly one single-cycle `io_ready_o` pulse. For a pointer or no-request access, the pulse comes one cycle after acceptance. For a window access, it comes in the cycle after the response and never while `cfg_req_o` is high. A target answering in the first request cycle gives completion two cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_req_i | input | 1 | I/O access request, held until `io_ready_o` |
| io_we_i | input | 1 | 1 = I/O write, 0 = I/O read |
| io_addr_i | input | IO_AW | I/O byte address |
| io_size_i | input | 2 | Access size: 0 byte, 1 word, 2 dword, 3 illegal |
| io_wdata_i | input | 32 | Right-aligned I/O write data |
| io_ready_o | output | 1 | One-cycle completion pulse |
| io_rdata_o | output | 32 | Right-aligned read data, valid with `io_ready_o` |
| cfg_req_o | output | 1 | Configuration request, held until response |
| cfg_we_o | output | 1 | 1 = configuration write |
| cfg_addr_o | output | 24 | {bus, device/function, dword offset, 2'b00} |
| cfg_be_o | output | 4 | Byte-lane enables |
| cfg_wdata_o | output | 32 | Lane-aligned write data |
| cfg_rsp_valid_i | input | 1 | Target response strobe |
| cfg_rdata_i | input | 32 | Target read dword, valid with the strobe |

## Verification
Two events can land in the same cycle. The target can return its response in the very first cycle that `cfg_req_o` is high, so request issue and response capture run back to back. The bench sweeps target latency from zero to three cycles for every start lane, size and direction. Each result is judged by the exact cycle of the `io_ready_o` pulse, the held request fields and the extracted read data. Pointer rewrites between window accesses confirm that each request carries the pointer value latched when it was issued.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = $clog2(LANES);
  localparam int unsigned DW     = LANES * 8;
  localparam int unsigned CFG_AW = 24;
  localparam int unsigned OFS_W  = 8 - LANE_W;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_BAD   = 2'd3
  } io_size_e;

  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_PTR  = 2'd1,
    HIT_WIN  = 2'd2
  } io_hit_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_DONE = 2'd2
  } ctrl_state_e;

  typedef enum logic [1:0] {
    RD_ONES = 2'd0,
    RD_PTR  = 2'd1,
    RD_RSP  = 2'd2
  } rd_src_e;

  typedef struct packed {
    logic [7:0]       bus;
    logic [7:0]       devfn;
    logic [OFS_W-1:0] dword;
  } cfg_target_t;

endpackage

// File: rtl/cfg_io_decode.sv
module cfg_io_decode
  import cfg_port_pkg::*;
#(
  parameter int unsigned     IO_AW    = 16,
  parameter logic [IO_AW-1:0] PTR_PORT = 16'hCF8,
  parameter logic [IO_AW-1:0] WIN_PORT = 16'hCFC
) (
  input  logic [IO_AW-1:0]  addr_i,
  input  io_size_e          size_i,
  output io_hit_e           hit_o,
  output logic [LANE_W-1:0] lane_o
);

  logic ptr_match;
  logic win_match;

  // pointer needs an exact dword access; window only compares the dword base
  assign ptr_match = (addr_i == PTR_PORT) && (size_i == SZ_DWORD);
  assign win_match = (addr_i[IO_AW-1:LANE_W] == WIN_PORT[IO_AW-1:LANE_W]) &&
                     (size_i != SZ_BAD);

  always_comb begin
    if (ptr_match)      hit_o = HIT_PTR;
    else if (win_match) hit_o = HIT_WIN;
    else                hit_o = HIT_NONE;
  end

  assign lane_o = addr_i[LANE_W-1:0];

endmodule

// File: rtl/cfg_lane_map.sv
module cfg_lane_map
  import cfg_port_pkg::*;
(
  input  logic [LANE_W-1:0] lane_i,
  input  io_size_e          size_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [DW-1:0]     rsp_i,
  output logic [LANES-1:0]  be_o,
  output logic [DW-1:0]     wdata_o,
  output logic [DW-1:0]     rdata_o
);

  logic [LANE_W:0] nbytes;
  logic [DW-1:0]   rsp_shift;

  always_comb begin
    case (size_i)
      SZ_BYTE: nbytes = (LANE_W+1)'(1);
      SZ_WORD: nbytes = (LANE_W+1)'(2);
      default: nbytes = (LANE_W+1)'(LANES);
    endcase
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      be_o[i] = (i >= int'(lane_i)) && ((i - int'(lane_i)) < int'(nbytes));
    end
  end

  assign wdata_o   = wdata_i << {lane_i, 3'b000};
  assign rsp_shift = rsp_i >> {lane_i, 3'b000};

  for (genvar j = 0; j < LANES; j++) begin : g_rd_byte
    assign rdata_o[8*j +: 8] = (nbytes > (LANE_W+1)'(j)) ? rsp_shift[8*j +: 8] : 8'h00;
  end

endmodule

// File: rtl/cfg_req_ctrl.sv
module cfg_req_ctrl
  import cfg_port_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    io_req_i,
  input  logic    io_we_i,
  input  io_hit_e hit_i,
  input  logic    win_en_i,
  input  logic    rsp_valid_i,
  output logic    ptr_wr_o,
  output logic    issue_o,
  output logic    rd_load_o,
  output rd_src_e rd_sel_o,
  output logic    cfg_req_o,
  output logic    io_ready_o
);

  ctrl_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    ptr_wr_o  = 1'b0;
    issue_o   = 1'b0;
    rd_load_o = 1'b0;
    rd_sel_o  = RD_ONES;
    unique case (state_q)
      ST_IDLE: begin
        if (io_req_i) begin
          unique case (hit_i)
            HIT_PTR: begin
              ptr_wr_o  = io_we_i;
              rd_load_o = 1'b1;
              rd_sel_o  = RD_PTR;
              state_d   = ST_DONE;
            end
            HIT_WIN: begin
              if (win_en_i) begin
                issue_o = 1'b1;
                state_d = ST_REQ;
              end else begin
                rd_load_o = 1'b1;
                state_d   = ST_DONE;
              end
            end
            default: begin
              rd_load_o = 1'b1;
              state_d   = ST_DONE;
            end
          endcase
        end
      end
      ST_REQ: begin
        if (rsp_valid_i) begin
          rd_load_o = 1'b1;
          rd_sel_o  = RD_RSP;
          state_d   = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign cfg_req_o  = (state_q == ST_REQ);
  assign io_ready_o = (state_q == ST_DONE);

endmodule

// File: rtl/cfg_access_port.sv
module cfg_access_port
  import cfg_port_pkg::*;
#(
  parameter int unsigned      IO_AW    = 16,
  parameter logic [IO_AW-1:0] PTR_PORT = 16'hCF8,
  parameter logic [IO_AW-1:0] WIN_PORT = 16'hCFC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_req_i,
  input  logic              io_we_i,
  input  logic [IO_AW-1:0]  io_addr_i,
  input  logic [1:0]        io_size_i,
  input  logic [31:0]       io_wdata_i,
  output logic              io_ready_o,
  output logic [31:0]       io_rdata_o,
  output logic              cfg_req_o,
  output logic              cfg_we_o,
  output logic [23:0]       cfg_addr_o,
  output logic [3:0]        cfg_be_o,
  output logic [31:0]       cfg_wdata_o,
  input  logic              cfg_rsp_valid_i,
  input  logic [31:0]       cfg_rdata_i
);

  localparam int unsigned EN_BIT = DW - 1;

  io_hit_e           hit;
  logic [LANE_W-1:0] lane;
  io_size_e          size_in;

  logic              ptr_wr, issue, rd_load;
  rd_src_e           rd_sel;

  logic [DW-1:0]     ptr_q;
  cfg_target_t       tgt_q;
  logic [LANE_W-1:0] lane_q;
  io_size_e          size_q;
  logic              we_q;
  logic [DW-1:0]     wdata_q;
  logic [DW-1:0]     rdata_q;
  logic [DW-1:0]     rsp_ext;

  assign size_in = io_size_e'(io_size_i);

  cfg_io_decode #(
    .IO_AW    (IO_AW),
    .PTR_PORT (PTR_PORT),
    .WIN_PORT (WIN_PORT)
  ) u_decode (
    .addr_i (io_addr_i),
    .size_i (size_in),
    .hit_o  (hit),
    .lane_o (lane)
  );

  cfg_req_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .io_req_i    (io_req_i),
    .io_we_i     (io_we_i),
    .hit_i       (hit),
    .win_en_i    (ptr_q[EN_BIT]),
    .rsp_valid_i (cfg_rsp_valid_i),
    .ptr_wr_o    (ptr_wr),
    .issue_o     (issue),
    .rd_load_o   (rd_load),
    .rd_sel_o    (rd_sel),
    .cfg_req_o   (cfg_req_o),
    .io_ready_o  (io_ready_o)
  );

  // lane map works on the captured access so request fields hold steady
  cfg_lane_map u_lanes (
    .lane_i  (lane_q),
    .size_i  (size_q),
    .wdata_i (wdata_q),
    .rsp_i   (cfg_rdata_i),
    .be_o    (cfg_be_o),
    .wdata_o (cfg_wdata_o),
    .rdata_o (rsp_ext)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (ptr_wr) ptr_q <= io_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q   <= '0;
      lane_q  <= '0;
      size_q  <= SZ_BYTE;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else if (issue) begin
      tgt_q.bus   <= ptr_q[23:16];
      tgt_q.devfn <= ptr_q[15:8];
      tgt_q.dword <= ptr_q[7:LANE_W];
      lane_q      <= lane;
      size_q      <= size_in;
      we_q        <= io_we_i;
      wdata_q     <= io_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd_load) begin
      unique case (rd_sel)
        RD_PTR:  rdata_q <= ptr_q;
        RD_RSP:  rdata_q <= rsp_ext;
        default: rdata_q <= '1;
      endcase
    end
  end

  assign io_rdata_o = rdata_q;
  assign cfg_we_o   = we_q;
  assign cfg_addr_o = {tgt_q.bus, tgt_q.devfn, tgt_q.dword, {LANE_W{1'b0}}};

endmodule

// File: rtl/cfg_access_port_chk.sv
module cfg_access_port_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        io_ready_o,
  input logic        cfg_req_o,
  input logic        cfg_we_o,
  input logic [23:0] cfg_addr_o,
  input logic [3:0]  cfg_be_o,
  input logic [31:0] cfg_wdata_o,
  input logic        cfg_rsp_valid_i,
  input logic        ptr_en_i
);

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && !cfg_rsp_valid_i |=> cfg_req_o && $stable(cfg_addr_o) &&
      $stable(cfg_be_o) && $stable(cfg_wdata_o) && $stable(cfg_we_o));

  // R9
  req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && cfg_rsp_valid_i |=> !cfg_req_o && io_ready_o);

  // R10
  no_ready_in_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> !io_ready_o);

  // R10
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_ready_o |=> !io_ready_o);

  // R4
  req_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> ptr_en_i);

  // R6
  be_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> $countones(cfg_be_o) != 0);

endmodule

bind cfg_access_port cfg_access_port_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .io_ready_o      (io_ready_o),
  .cfg_req_o       (cfg_req_o),
  .cfg_we_o        (cfg_we_o),
  .cfg_addr_o      (cfg_addr_o),
  .cfg_be_o        (cfg_be_o),
  .cfg_wdata_o     (cfg_wdata_o),
  .cfg_rsp_valid_i (cfg_rsp_valid_i),
  .ptr_en_i        (ptr_q[31])
);

// File: tb/cfg_access_port_bench.sv
module cfg_access_port_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_req = 1'b0;
  logic        io_we = 1'b0;
  logic [15:0] io_addr = '0;
  logic [1:0]  io_size = '0;
  logic [31:0] io_wdata = '0;
  logic        io_ready;
  logic [31:0] io_rdata;
  logic        cfg_req;
  logic        cfg_we;
  logic [23:0] cfg_addr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cfg_access_port u_cfg_access_port (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .io_req_i        (io_req),
    .io_we_i         (io_we),
    .io_addr_i       (io_addr),
    .io_size_i       (io_size),
    .io_wdata_i      (io_wdata),
    .io_ready_o      (io_ready),
    .io_rdata_o      (io_rdata),
    .cfg_req_o       (cfg_req),
    .cfg_we_o        (cfg_we),
    .cfg_addr_o      (cfg_addr),
    .cfg_be_o        (cfg_be),
    .cfg_wdata_o     (cfg_wdata),
    .cfg_rsp_valid_i (rsp_valid),
    .cfg_rdata_i     (rsp_data)
  );

  function automatic logic [31:0] pattern(input logic [23:0] a);
    return ({8'h00, a} * 32'h9E3779B1) ^ 32'h5AC3_0F96;
  endfunction

  // target model
  int          lat = 0;
  int          req_count = 0;
  int          stab_err = 0;
  bit          active = 0;
  int          wait_n = 0;
  logic [23:0] cap_addr;
  logic [3:0]  cap_be;
  logic [31:0] cap_wdata;
  logic        cap_we;

  initial begin
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (rst_n && cfg_req) begin
        if (!active) begin
          active = 1; wait_n = 0;
          cap_addr = cfg_addr; cap_be = cfg_be; cap_wdata = cfg_wdata; cap_we = cfg_we;
        end else if (cfg_addr != cap_addr || cfg_be != cap_be ||
                     cfg_wdata != cap_wdata || cfg_we != cap_we) begin
          stab_err++;
        end
        if (wait_n == lat) begin
          rsp_valid = 1'b1;
          rsp_data  = pattern(cap_addr);
          req_count++;
          active = 0;
        end else begin
          wait_n++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [31:0] rd_val;
  int          n_cyc;

  task automatic io_access(input bit we, input logic [15:0] a, input logic [1:0] sz,
                           input logic [31:0] wd);
    io_req = 1'b1; io_we = we; io_addr = a; io_size = sz; io_wdata = wd;
    n_cyc = 0;
    rd_val = 'x;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      n_cyc++;
      if (io_ready) begin
        rd_val = io_rdata;
        break;
      end
    end
    io_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    logic [31:0] ptrs [2];
    logic [31:0] full, wd, exp_rd, ptr_keep;
    logic [3:0]  exp_be;
    logic [23:0] exp_addr;
    int          rc;

    ptrs[0] = 32'hAA00_0807;
    ptrs[1] = 32'hD5A5_FFFE;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(io_ready == 1'b0, "R1 ready in reset", {31'b0, io_ready}, 32'h0);
    chk(cfg_req == 1'b0, "R1 req in reset", {31'b0, cfg_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(io_ready == 1'b0 && cfg_req == 1'b0, "R1 idle after reset",
        {30'b0, io_ready, cfg_req}, 32'h0);
    io_access(0, 16'hCF8, 2'd2, 0);
    chk(rd_val == 32'h0, "R1 pointer reset value", rd_val, 32'h0);

    // R2 pointer round trip
    foreach (ptrs[i]) begin
      io_access(1, 16'hCF8, 2'd2, ptrs[i]);
      chk(n_cyc == 1, "R10 pointer write latency", n_cyc, 1);
      io_access(0, 16'hCF8, 2'd2, 0);
      chk(rd_val == ptrs[i], "R2 pointer readback", rd_val, ptrs[i]);
    end
    io_access(1, 16'hCF8, 2'd2, 32'hFFFF_FFFF);
    io_access(0, 16'hCF8, 2'd2, 0);
    chk(rd_val == 32'hFFFF_FFFF, "R2 pointer all ones", rd_val, 32'hFFFF_FFFF);

    // R3 accesses that must not touch pointer or target
    ptr_keep = 32'h8012_3456;
    io_access(1, 16'hCF8, 2'd2, ptr_keep);
    rc = req_count;
    io_access(1, 16'hCF8, 2'd0, 32'h0);
    io_access(1, 16'hCF8, 2'd1, 32'h0);
    io_access(1, 16'hCF9, 2'd2, 32'h0);
    io_access(1, 16'hCFB, 2'd0, 32'h0);
    io_access(1, 16'h0080, 2'd2, 32'h0);
    io_access(1, 16'hCFC, 2'd3, 32'h0);
    io_access(0, 16'hCF8, 2'd2, 0);
    chk(rd_val == ptr_keep, "R3 pointer untouched", rd_val, ptr_keep);
    io_access(0, 16'hCF8, 2'd0, 0);
    chk(rd_val == 32'hFFFF_FFFF, "R3 byte pointer read", rd_val, 32'hFFFF_FFFF);
    io_access(0, 16'hCFA, 2'd1, 0);
    chk(rd_val == 32'hFFFF_FFFF, "R3 gap read", rd_val, 32'hFFFF_FFFF);
    io_access(0, 16'h0080, 2'd2, 0);
    chk(rd_val == 32'hFFFF_FFFF, "R3 unmapped read", rd_val, 32'hFFFF_FFFF);
    chk(n_cyc == 1, "R10 unmapped latency", n_cyc, 1);
    chk(req_count == rc, "R3 no request", req_count, rc);

    // R4 window disabled
    io_access(1, 16'hCF8, 2'd2, 32'h7FFF_FFFC);
    rc = req_count;
    for (int l = 0; l < 4; l++) begin
      io_access(0, 16'hCFC + 16'(l), 2'd0, 0);
      chk(rd_val == 32'hFFFF_FFFF, "R4 disabled read", rd_val, 32'hFFFF_FFFF);
      io_access(1, 16'hCFC + 16'(l), 2'd2, 32'h1234_5678);
    end
    chk(req_count == rc, "R4 no request while disabled", req_count, rc);

    // R5..R10 sweep
    foreach (ptrs[p]) begin
      io_access(1, 16'hCF8, 2'd2, ptrs[p]);
      exp_addr = {ptrs[p][23:2], 2'b00};
      for (int lt = 0; lt < 4; lt++) begin
        lat = lt;
        for (int l = 0; l < 4; l++) begin
          for (int s = 0; s < 3; s++) begin
            for (int w = 0; w < 2; w++) begin
              full   = (s == 0) ? 32'h0000_00FF : (s == 1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
              exp_be = 4'((((s == 0) ? 1 : (s == 1) ? 3 : 15) << l) & 15);
              wd     = 32'hC001_0000 + 32'(p * 1000 + lt * 100 + l * 10 + s);
              rc     = req_count;
              io_access(w[0], 16'hCFC + 16'(l), 2'(s), wd);
              chk(req_count == rc + 1, "R10 one request", req_count, rc + 1);
              chk(n_cyc == lt + 2, "R10 completion cycle", n_cyc, lt + 2);
              chk(stab_err == 0, "R9 request held stable", stab_err, 0);
              chk(cap_addr == exp_addr, "R5 config address", {8'h0, cap_addr}, {8'h0, exp_addr});
              chk(cap_be == exp_be, "R6 byte enables", {28'h0, cap_be}, {28'h0, exp_be});
              chk(cap_we == w[0], "R10 direction", {31'h0, cap_we}, {31'h0, w[0]});
              if (w == 1) begin
                chk(cap_wdata == (wd << (8 * l)), "R7 write data lanes", cap_wdata, wd << (8 * l));
              end else begin
                exp_rd = (pattern(exp_addr) >> (8 * l)) & full;
                chk(rd_val == exp_rd, "R8 read data extract", rd_val, exp_rd);
              end
            end
          end
        end
      end
    end

    finish_run();
  end

endmodule